// File: doc/BRIEF.md
# Downstream Port Power Guard

This block drives the power switch of each downstream port of a hub and watches the over-current flag that the switch returns for it. Both pins are active low: a low enable output turns port power on, and a low sense input reports an over-current. The hub logic turns ports on and off with single-cycle command pulses. When a sense input stays low long enough while its port is powered, the block cuts power to that port. It then raises a sticky fault flag and a sticky change flag, which stay set until the hub logic clears them.

All delays are counted in ticks from an internal prescaler. With the default parameters a tick is 1 µs on a 30 MHz clock. The sense path is ignored while a port is unpowered. It is also ignored during a settling window after power-on, so that the inrush current of a newly attached device does not trip the port. After that window, the sense input must stay low for a run of consecutive ticks before the port trips, which rejects short glitches. With the defaults, a fault is cut after 4 ms of continuous low, which lies inside the required 4–5 ms response window.

In ganged mode, every port shares one power state. Any power-on or power-off command bit acts on all ports. Only sense input 0 is watched, and a fault on it removes power from every port and flags all of them. The mode input is expected to change only while reset is held.

Top module: `port_power_guard`

## Requirements
- R1: While the asynchronous active-low reset is asserted, and right after it is released, every enable output is high (power off) and every fault and change flag is 0.
- R2: In individual mode, a power-on pulse on bit i drives enable output i low from the next clock edge. A power-off pulse on bit i drives it high from the next edge. Other ports are not affected, and power-off wins when both pulses arrive together.
- R3: Once port i is powered and its settling window has passed, a sense input held low for DET_TICKS consecutive ticks drives enable output i high. This happens between (DET_TICKS-1)*TICK_DIV and DET_TICKS*TICK_DIV+2 clock cycles after the sense input goes low.
- R4: While port i is unpowered, its sense input has no effect: a low level sets no flag.
- R5: During the first BLANK_TICKS ticks after power-on, the sense input of that port is ignored. The low-run count starts only once this window has ended.
- R6: A sense low that returns high before DET_TICKS ticks have passed does not trip the port, and the run count restarts from zero.
- R7: A trip sets fault flag i and change flag i. Each flag stays set until its own clear pulse arrives. The port stays unpowered, even after the sense input returns high, until a new power-on command.
- R8: In ganged mode, any power-on bit powers all ports and any power-off bit unpowers all ports. Sense inputs 1 and up are ignored. A qualified fault on sense input 0 unpowers every port and sets every fault flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gang_mode | input | 1 | 1: ganged power and global sense; 0: per-port control |
| pwr_on_req | input | NPORTS | Single-cycle power-on commands, one per port |
| pwr_off_req | input | NPORTS | Single-cycle power-off commands, one per port |
| clr_fault | input | NPORTS | Clears the sticky fault flag of each port |
| clr_change | input | NPORTS | Clears the sticky change flag of each port |
| oc_sense_n | input | NPORTS | Active-low over-current sense, one per port (bit 0 is the global sense in ganged mode) |
| pwr_en_n | output | NPORTS | Active-low power enable, one per port |
| oc_fault | output | NPORTS | Sticky over-current flag, one per port |
| oc_change | output | NPORTS | Sticky flag marking that the fault flag was set |

## Verification
The assertions check these on every cycle: a command to power on an unpowered port takes effect at the next edge; a rising fault flag always comes with power being removed in the same cycle; an unpowered port never raises a fault; the flags stay set until cleared; and ganged mode never leaves the ports at mixed power levels. The bench scenarios are needed for the behaviour that depends on time: the length of the response window, rejection of glitches shorter than the qualification run, and the settling window that hides inrush current after power-on. They also show that the global sense input powers down every port while the other sense inputs are ignored.

// File: rtl/port_power_guard.sv
module port_power_guard #(
  parameter int NPORTS      = 4,
  parameter int TICK_DIV    = 30,
  parameter int BLANK_TICKS = 4000,
  parameter int DET_TICKS   = 4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gang_mode,
  input  logic [NPORTS-1:0] pwr_on_req,
  input  logic [NPORTS-1:0] pwr_off_req,
  input  logic [NPORTS-1:0] clr_fault,
  input  logic [NPORTS-1:0] clr_change,
  input  logic [NPORTS-1:0] oc_sense_n,
  output logic [NPORTS-1:0] pwr_en_n,
  output logic [NPORTS-1:0] oc_fault,
  output logic [NPORTS-1:0] oc_change
);
  localparam int DW = $clog2(TICK_DIV + 1);
  localparam int BW = $clog2(BLANK_TICKS + 1);
  localparam int TW = $clog2(DET_TICKS + 1);

  logic [DW-1:0] div_cnt;
  wire tick = (div_cnt == DW'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    div_cnt <= '0;
    else if (tick) div_cnt <= '0;
    else           div_cnt <= div_cnt + 1'b1;

  wire any_on  = |pwr_on_req;
  wire any_off = |pwr_off_req;

  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    logic          pwr;
    logic [BW-1:0] blank_cnt;
    logic [TW-1:0] run_cnt;

    wire on_cmd  = gang_mode ? any_on  : pwr_on_req[i];
    wire off_cmd = gang_mode ? any_off : pwr_off_req[i];
    wire low     = gang_mode ? !oc_sense_n[0] : !oc_sense_n[i];
    wire armed   = (blank_cnt == BW'(BLANK_TICKS));
    wire trip    = pwr && armed && low && tick && (run_cnt == TW'(DET_TICKS - 1));

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        pwr         <= 1'b0;
        blank_cnt   <= '0;
        run_cnt     <= '0;
        oc_fault[i]  <= 1'b0;
        oc_change[i] <= 1'b0;
      end else begin
        if (trip || off_cmd) pwr <= 1'b0;
        else if (on_cmd)     pwr <= 1'b1;

        if (!pwr)                blank_cnt <= '0;
        else if (tick && !armed) blank_cnt <= blank_cnt + 1'b1;

        if (!pwr || !armed || !low) run_cnt <= '0;
        else if (tick)              run_cnt <= run_cnt + 1'b1;

        if (trip)               oc_fault[i] <= 1'b1;
        else if (clr_fault[i])  oc_fault[i] <= 1'b0;

        if (trip)               oc_change[i] <= 1'b1;
        else if (clr_change[i]) oc_change[i] <= 1'b0;
      end

    assign pwr_en_n[i] = !pwr;

    assert_power_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_en_n[i] && pwr_on_req[i] && !pwr_off_req[i] && !gang_mode |=> !pwr_en_n[i]);
    assert_fault_cuts_power_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oc_fault[i]) |-> pwr_en_n[i] && $past(!pwr_en_n[i]));
    assert_ignore_unpowered_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(pwr_en_n[i]) |-> !$rose(oc_fault[i]));
    assert_sticky_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
      oc_fault[i] && !clr_fault[i] |=> oc_fault[i]);
  end

  assert_gang_uniform_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gang_mode && $past(gang_mode) |-> ($countones(pwr_en_n) == 0 || $countones(pwr_en_n) == NPORTS));
endmodule

// File: tb/port_power_guard_test.sv
module port_power_guard_test;
  localparam int N = 4, DIV = 4, BLANK = 5, DET = 6;

  logic clk = 0, rst_n = 0, gang_mode = 0;
  logic [N-1:0] on_r = '0, off_r = '0, clr_f = '0, clr_c = '0, sense_n = '1;
  logic [N-1:0] pwr_en_n, oc_fault, oc_change;
  int checks = 0, fails = 0;
  bit  done = 0;

  always #2 clk = ~clk;

  port_power_guard #(.NPORTS(N), .TICK_DIV(DIV), .BLANK_TICKS(BLANK), .DET_TICKS(DET)) uut (
    .clk(clk), .rst_n(rst_n), .gang_mode(gang_mode), .pwr_on_req(on_r), .pwr_off_req(off_r),
    .clr_fault(clr_f), .clr_change(clr_c), .oc_sense_n(sense_n),
    .pwr_en_n(pwr_en_n), .oc_fault(oc_fault), .oc_change(oc_change));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic gang);
    rst_n = 0; gang_mode = gang;
    on_r = '0; off_r = '0; clr_f = '0; clr_c = '0; sense_n = '1;
    wait_cyc(3);
    rst_n = 1;
    wait_cyc(1);
  endtask

  task automatic pulse_on(input logic [N-1:0] m);
    on_r = m; @(negedge clk); on_r = '0;
  endtask

  task automatic pulse_off(input logic [N-1:0] m);
    off_r = m; @(negedge clk); off_r = '0;
  endtask

  task automatic t_reset;
    rst_n = 0; wait_cyc(2);
    chk(pwr_en_n == 4'hF, "R1 enables in reset", pwr_en_n, 4'hF);
    do_reset(0);
    chk(pwr_en_n == 4'hF, "R1 enables after reset", pwr_en_n, 4'hF);
    chk(oc_fault == 0 && oc_change == 0, "R1 flags after reset", {oc_fault, oc_change}, 0);
  endtask

  task automatic t_power;
    do_reset(0);
    pulse_on(4'b0010);
    chk(pwr_en_n == 4'b1101, "R2 power on port1", pwr_en_n, 4'b1101);
    pulse_on(4'b1000);
    chk(pwr_en_n == 4'b0101, "R2 power on port3", pwr_en_n, 4'b0101);
    pulse_off(4'b0010);
    chk(pwr_en_n == 4'b0111, "R2 power off port1", pwr_en_n, 4'b0111);
    on_r = 4'b0001; off_r = 4'b0001; @(negedge clk); on_r = '0; off_r = '0;
    chk(pwr_en_n[0], "R2 off wins over on", pwr_en_n[0], 1);
  endtask

  task automatic t_unpowered;
    do_reset(0);
    sense_n = 4'b0000;
    wait_cyc((BLANK + DET) * DIV * 3);
    sense_n = '1;
    chk(oc_fault == 0 && oc_change == 0, "R4 sense ignored while off", {oc_fault, oc_change}, 0);
  endtask

  task automatic t_trip;
    int n = 0;
    do_reset(0);
    pulse_on(4'b0101);
    wait_cyc(BLANK * DIV + 8);
    sense_n[2] = 0;
    while (!pwr_en_n[2] && n < 500) begin @(negedge clk); n++; end
    chk(n >= (DET - 1) * DIV && n <= DET * DIV + 2, "R3 response time", n, DET * DIV);
    chk(pwr_en_n == 4'b1110, "R3 only faulty port cut", pwr_en_n, 4'b1110);
    chk(oc_fault == 4'b0100 && oc_change == 4'b0100, "R7 flags set", {oc_fault, oc_change}, 8'h44);
    sense_n[2] = 1;
    wait_cyc(40);
    chk(pwr_en_n[2] && oc_fault[2], "R7 stays off and flagged", {pwr_en_n[2], oc_fault[2]}, 3);
    clr_c = 4'b0100; @(negedge clk); clr_c = '0;
    chk(oc_change[2] == 0 && oc_fault[2] == 1, "R7 change cleared alone", {oc_change[2], oc_fault[2]}, 1);
    clr_f = 4'b0100; @(negedge clk); clr_f = '0;
    chk(oc_fault[2] == 0, "R7 fault cleared", oc_fault[2], 0);
    pulse_on(4'b0100);
    chk(pwr_en_n[2] == 0, "R7 new power-on restores", pwr_en_n[2], 0);
  endtask

  task automatic t_glitch;
    do_reset(0);
    pulse_on(4'b0001);
    wait_cyc(BLANK * DIV + 8);
    repeat (3) begin
      sense_n[0] = 0; wait_cyc((DET - 2) * DIV);
      sense_n[0] = 1; wait_cyc(2);
    end
    wait_cyc(10);
    chk(pwr_en_n[0] == 0 && oc_fault[0] == 0, "R6 glitches rejected", {pwr_en_n[0], oc_fault[0]}, 0);
  endtask

  task automatic t_blank;
    do_reset(0);
    sense_n[3] = 0;
    pulse_on(4'b1000);
    wait_cyc((BLANK + DET - 3) * DIV - 1);
    sense_n[3] = 1;
    wait_cyc(10);
    chk(pwr_en_n[3] == 0 && oc_fault[3] == 0, "R5 inrush blanked", {pwr_en_n[3], oc_fault[3]}, 0);
  endtask

  task automatic t_gang;
    int n = 0;
    do_reset(1);
    pulse_on(4'b0100);
    chk(pwr_en_n == 4'b0000, "R8 gang power on", pwr_en_n, 0);
    wait_cyc(BLANK * DIV + 8);
    sense_n[3] = 0;
    wait_cyc((DET + 3) * DIV);
    sense_n[3] = 1;
    chk(pwr_en_n == 4'b0000 && oc_fault == 0, "R8 non-global sense ignored", {pwr_en_n, oc_fault}, 0);
    sense_n[0] = 0;
    while (pwr_en_n != 4'hF && n < 500) begin @(negedge clk); n++; end
    sense_n[0] = 1;
    chk(pwr_en_n == 4'hF, "R8 global fault cuts all", pwr_en_n, 4'hF);
    chk(oc_fault == 4'hF, "R8 all flags set", oc_fault, 4'hF);
    pulse_on(4'b0001);
    pulse_off(4'b1000);
    chk(pwr_en_n == 4'hF, "R8 gang power off", pwr_en_n, 4'hF);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_power();
    t_unpowered();
    t_trip();
    t_glitch();
    t_blank();
    t_gang();
    finish_run();
  end
endmodule